// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the datapath of one DMA channel. Each accepted transfer strobe moves the channel's current address by one and takes one off its current count. When the count wraps below zero, the block raises a terminal-count pulse. A host register file programs the channel with a base address, a base count, a page value and three mode bits: word width, address direction and auto-initialize. The block then presents a 16-bit current address and a page-extended physical address to the bus-cycle logic.

The count is programmed as the number of transfers minus one. A base count of 0x0000 therefore gives one transfer, and 0xFFFF gives 65536 transfers. The 16-bit address wraps inside its page, and the page value is never changed by the engine. A transfer therefore stays inside a 64K-byte window in byte mode and a 128K-byte window in word mode. In word mode the count is in 16-bit words.

A two-state machine controls whether strobes are accepted:

- **MASKED**: this is the reset state. Strobes are ignored here. The transition ARM moves it to RUN.
- **RUN**: strobes are accepted here. The transition FINISH returns it to MASKED on terminal count when auto-initialize is off. The transition RELOAD stays in RUN on terminal count when auto-initialize is on, and copies both base registers back into the current registers.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, the channel is masked (`masked`=1), `cur_addr`=0, `cur_count`=0 and `tc`=0.
- R2: A cycle with `load`=1 writes `base_addr` and `base_count` into both the base and current registers, visible after that clock edge. Load has priority over a strobe in the same cycle, and that strobe is not accepted.
- R3: An accepted strobe adds 1 to `cur_addr` when `dir_down`=0 and subtracts 1 when `dir_down`=1. The address wraps modulo 2^16 and the page bits of `phys_addr` do not change.
- R4: An accepted strobe subtracts 1 from `cur_count`. A base count of N-1 gives exactly N accepted strobes before terminal count. After completion, `cur_count`+1 is 0 modulo 2^16.
- R5: `tc` is high for exactly the one cycle after an accepted strobe that found `cur_count`=0x0000.
- R6: FINISH: when auto-initialize is off, terminal count takes the channel to MASKED. The count reads 0xFFFF and the address has advanced once more.
- R7: RELOAD: when `auto_init`=1, terminal count copies the base address and base count into the current registers, and the channel stays in RUN.
- R8: While the channel is masked, `xfer` has no effect on `cur_addr`, `cur_count` or `tc`.
- R9: ARM: a cycle with `arm`=1 in MASKED moves the channel to RUN (`masked`=0) after the clock edge.
- R10: In byte mode (`word_mode`=0), `phys_addr` = {page[7:0], cur_addr[15:0]}.
- R11: In word mode (`word_mode`=1), `phys_addr` = {page[7:1], cur_addr[15:0], 1'b0}. Page bit 0 is ignored and bit 0 of the physical address is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Program the base and current registers |
| base_addr | input | 16 | Base address to program |
| base_count | input | 16 | Base count (transfers minus one) |
| page | input | 8 | Page value supplying the upper physical bits |
| word_mode | input | 1 | 1: 16-bit transfers, 0: byte transfers |
| dir_down | input | 1 | 1: decrement the address, 0: increment it |
| auto_init | input | 1 | Reload from the base registers on terminal count |
| arm | input | 1 | Unmask the channel |
| xfer | input | 1 | Transfer acknowledge strobe |
| cur_addr | output | 16 | Current address |
| cur_count | output | 16 | Current count (residue) |
| phys_addr | output | 24 | Page-extended physical address |
| tc | output | 1 | Terminal-count pulse |
| masked | output | 1 | Channel is in MASKED |

## Verification
A behavioural model in the bench is compared against the outputs on every clock.

- **Count sizes:** runs with base counts of 0 and 3 separate a correct N-1 preload from an off-by-one on either side.
- **Address wrap:** a run across 0xFFFF shows the address wrapping with the page held, where a faulty design would carry into the page.
- **Direction and width:** decrement runs and word-mode runs, with page bit 0 set, tell the two directions and the two address mappings apart.
- **Masking and load:** strobes while masked, and a strobe in the same cycle as a load, show that ignored strobes really are ignored.
- **Strobe spacing:** auto-initialize runs with gapped and back-to-back strobes separate RELOAD from FINISH.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
    typedef enum logic {
        CH_MASKED = 1'b0,
        CH_RUN    = 1'b1
    } ch_state_e;
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              step,
    input  logic              reload,
    input  logic              dir_down,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            addr_q <= '0;
        end else if (load) begin
            base_q <= base_in;
            addr_q <= base_in;
        end else if (reload) begin
            addr_q <= base_q;
        end else if (step) begin
            addr_q <= dir_down ? addr_q - ADDR_W'(1) : addr_q + ADDR_W'(1);
        end
    end

    assign addr = addr_q;

    // R3: an upward step adds exactly one, with modulo wrap
    p_addr_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !reload && !dir_down) |=> addr == $past(addr) + ADDR_W'(1));
    // R3: a downward step subtracts exactly one
    p_addr_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !reload && dir_down) |=> addr == $past(addr) - ADDR_W'(1));
endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] base_in,
    input  logic             step,
    input  logic             reload,
    output logic [CNT_W-1:0] count,
    output logic             at_zero
);
    logic [CNT_W-1:0] base_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= base_in;
            cnt_q  <= base_in;
        end else if (reload) begin
            cnt_q <= base_q;
        end else if (step) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign count   = cnt_q;
    assign at_zero = (cnt_q == '0);

    // R4: each accepted step takes one off the count
    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !reload) |=> count == $past(count) - CNT_W'(1));
    // R7: a reload restores the value last loaded
    p_count_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !load) |=> count == $past(base_q));
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8,
    localparam int PHYS_W = PAGE_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] base_count,
    input  logic [PAGE_W-1:0] page,
    input  logic              word_mode,
    input  logic              dir_down,
    input  logic              auto_init,
    input  logic              arm,
    input  logic              xfer,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] cur_count,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              tc,
    output logic              masked
);
    ch_state_e state_q, state_d;
    logic go, at_zero, reload, tc_q;

    assign go     = (state_q == CH_RUN) && xfer && !load;
    assign reload = go && at_zero && auto_init;

    dma_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(load), .base_in(base_addr),
        .step(go), .reload(reload), .dir_down(dir_down), .addr(cur_addr)
    );

    dma_count_unit #(.CNT_W(ADDR_W)) u_count (
        .clk(clk), .rst_n(rst_n), .load(load), .base_in(base_count),
        .step(go), .reload(reload), .count(cur_count), .at_zero(at_zero)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_MASKED;
            tc_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            tc_q    <= go && at_zero;
        end
    end

    // Next state: ARM, FINISH, RELOAD (stay)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_MASKED: if (arm) state_d = CH_RUN;
            CH_RUN:    if (go && at_zero && !auto_init) state_d = CH_MASKED;
            default:   state_d = CH_MASKED;
        endcase
    end

    // Outputs
    always_comb begin
        masked = (state_q == CH_MASKED);
        tc     = tc_q;
        if (word_mode) phys_addr = {page[PAGE_W-1:1], cur_addr, 1'b0};
        else           phys_addr = {page, cur_addr};
    end

    // R6: terminal count without auto-initialize masks the channel
    p_finish_masks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (go && at_zero && !auto_init) |=> (masked && tc));
    // R7: terminal count with auto-initialize keeps the channel running
    p_reload_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (go && at_zero && auto_init) |=> (!masked && tc));
    // R8: a masked channel without load holds its address and count
    p_masked_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (masked && !load) |=> ($stable(cur_addr) && $stable(cur_count) && !tc));
    // R5: terminal count only follows a strobe taken at zero
    p_tc_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(go && at_zero)) |=> !tc);
endmodule

// File: tb/tb_dma_chan_engine.sv
module tb_dma_chan_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 0, word_mode = 0, dir_down = 0, auto_init = 0, arm = 0, xfer = 0;
    logic [15:0] base_addr = 0, base_count = 0;
    logic [7:0]  page = 0;
    logic [15:0] cur_addr, cur_count;
    logic [23:0] phys_addr;
    logic        tc, masked;

    int n_chk = 0, n_fail = 0, tc_seen = 0;
    bit done = 0;

    // model state
    logic [15:0] m_addr = 0, m_cnt = 0, m_baddr = 0, m_bcnt = 0;
    logic        m_masked = 1, m_tc = 0;

    always #5 clk = ~clk;

    dma_chan_engine dut (
        .clk(clk), .rst_n(rst_n), .load(load), .base_addr(base_addr),
        .base_count(base_count), .page(page), .word_mode(word_mode),
        .dir_down(dir_down), .auto_init(auto_init), .arm(arm), .xfer(xfer),
        .cur_addr(cur_addr), .cur_count(cur_count), .phys_addr(phys_addr),
        .tc(tc), .masked(masked)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model, updated at each edge from the stable inputs
    always @(posedge clk) begin
        bit go, was_masked;
        if (!rst_n) begin
            m_addr = 0; m_cnt = 0; m_baddr = 0; m_bcnt = 0; m_masked = 1; m_tc = 0;
        end else begin
            was_masked = m_masked;
            go = !was_masked && xfer && !load;
            m_tc = go && (m_cnt == 16'h0000);
            if (load) begin
                m_baddr = base_addr; m_bcnt = base_count;
                m_addr = base_addr;  m_cnt = base_count;
            end else if (go) begin
                if (m_tc && auto_init) begin
                    m_addr = m_baddr; m_cnt = m_bcnt;
                end else begin
                    m_addr = dir_down ? m_addr - 16'd1 : m_addr + 16'd1;
                    m_cnt  = m_cnt - 16'd1;
                    if (m_tc) m_masked = 1;
                end
            end
            if (was_masked && arm) m_masked = 0;
        end
    end

    // compare every clock, away from the edge
    always @(negedge clk) begin
        logic [23:0] m_phys;
        if (rst_n && !done) begin
            m_phys = word_mode ? {page[7:1], m_addr, 1'b0} : {page, m_addr};
            chk(cur_addr == m_addr, "R3 address", 32'(cur_addr), 32'(m_addr));
            chk(cur_count == m_cnt, "R4 count", 32'(cur_count), 32'(m_cnt));
            chk(tc == m_tc, "R5 terminal count", 32'(tc), 32'(m_tc));
            chk(masked == m_masked, "R6/R9 mask state", 32'(masked), 32'(m_masked));
            chk(phys_addr == m_phys, word_mode ? "R11 word phys" : "R10 byte phys",
                32'(phys_addr), 32'(m_phys));
            if (tc) tc_seen++;
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic program_ch(input logic [15:0] a, input logic [15:0] c);
        load = 1; base_addr = a; base_count = c; tick(); load = 0;
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin xfer = 1; tick(); end
        xfer = 0;
    endtask

    initial begin
        #1500000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        tick(); tick(); tick();
        rst_n = 1; #1;
        // R1 reset state
        chk(masked == 1 && cur_addr == 0 && cur_count == 0 && tc == 0, "R1 reset",
            {masked, tc, cur_addr[13:0], cur_count}, 32'h8000_0000);
        tick();
        // R2 load, R8 strobes while masked
        page = 8'h56;
        program_ch(16'h1234, 16'd3);
        #4; chk(cur_addr == 16'h1234 && cur_count == 16'd3, "R2 load", {cur_addr, cur_count}, 32'h1234_0003);
        strobes(2);
        #4; chk(cur_addr == 16'h1234 && cur_count == 16'd3, "R8 masked ignores xfer",
               {cur_addr, cur_count}, 32'h1234_0003);
        // R9 arm, then R4/R5/R6: count 3 gives 4 transfers
        arm = 1; tick(); arm = 0;
        #4; chk(masked == 0, "R9 arm", 32'(masked), 0);
        tc_seen = 0;
        strobes(6); tick();
        chk(tc_seen == 1, "R5 single tc", tc_seen, 1);
        chk(cur_addr == 16'h1238, "R4 four transfers", 32'(cur_addr), 32'h1238);
        chk(16'(cur_count + 16'd1) == 16'h0, "R4 residue zero", 32'(cur_count), 32'hffff);
        chk(masked == 1, "R6 finish masks", 32'(masked), 1);
        // R3 wrap within page
        program_ch(16'hFFFE, 16'd4); arm = 1; tick(); arm = 0;
        strobes(3); #1;
        chk(phys_addr == 24'h56_0001, "R3 wrap keeps page", phys_addr, 32'h56_0001);
        // R3 decrement across zero
        dir_down = 1;
        program_ch(16'h0001, 16'd5); arm = 1; tick(); arm = 0;
        strobes(3); #1;
        chk(cur_addr == 16'hFFFE, "R3 decrement", 32'(cur_addr), 32'hFFFE);
        dir_down = 0;
        // R11 word mode, page bit 0 ignored
        word_mode = 1; page = 8'h57;
        program_ch(16'h8000, 16'd0); arm = 1; tick(); arm = 0;
        #1; chk(phys_addr == 24'h57_0000 - 24'h01_0000 + 24'h01_0000 && phys_addr == {7'h2B, 16'h8000, 1'b0},
               "R11 word phys", phys_addr, {7'h2B, 16'h8000, 1'b0});
        tc_seen = 0;
        strobes(3); tick();
        chk(tc_seen == 1 && masked, "R4 count zero gives one transfer", tc_seen, 1);
        word_mode = 0; page = 8'h10;
        // R7 auto-initialize with gapped and back-to-back strobes
        auto_init = 1;
        program_ch(16'h0100, 16'd1); arm = 1; tick(); arm = 0;
        tc_seen = 0;
        xfer = 1; tick(); xfer = 0; tick(); xfer = 1; tick(); xfer = 0; tick();
        strobes(4); tick();
        chk(tc_seen == 3 && !masked, "R7 reload stays running", tc_seen, 3);
        chk(cur_addr == 16'h0100 && cur_count == 16'd1, "R7 reload values",
            {cur_addr, cur_count}, 32'h0100_0001);
        // R2 load beats a simultaneous strobe
        auto_init = 0;
        load = 1; xfer = 1; base_addr = 16'h2000; base_count = 16'd7; tick(); load = 0; xfer = 0;
        #1; chk(cur_addr == 16'h2000 && cur_count == 16'd7, "R2 load priority",
               {cur_addr, cur_count}, 32'h2000_0007);
        strobes(2); tick();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule